// File: doc/BRIEF.md
# Full-speed serial bus packet receiver

This block sits behind a full-speed USB front end that has already turned the differential pair into one line state per bit time: J, K or single-ended zero (SE0). Each clock cycle carries exactly one line state. The block has two states. In HUNT it watches for the start pattern. In BODY it decodes NRZI, removes stuffed bits and collects the unstuffed bits LSB first until the end-of-packet pattern arrives. On that end it sorts the packet by how many bits it collected, then checks the packet identifier (PID) and the CRC of that class.

A good token reports its direction, its 7-bit device address and its 4-bit endpoint. A good single-byte data packet reports its payload byte. A token that fails any check is dropped with an error pulse, and the receiver then waits for another token. Data packets that arrive while no good token has been seen since reset, or since the last failed token, are ignored. Good handshakes pass quietly.

There are two transitions. HUNT goes to BODY when the start pattern ends on the current line state. BODY goes to HUNT when the end pattern ends on the current line state. There is no other exit from BODY.

Top module: `usbfs_pkt_rx`

## Requirements
- R1: While reset is held and in the cycle after it is released, `tok_valid`, `dat_valid` and `pkt_err` are 0. Line states are encoded as SE0=2'b00, J=2'b01, K=2'b10.
- R2: A packet starts only after the line states K,J,K,J,K,J,K,K have been seen in consecutive cycles. Line activity without that pattern, even if it ends with an end pattern, produces no pulse.
- R3: A packet ends on the line states SE0,SE0,J. Its result pulse (`tok_valid`, `dat_valid` or `pkt_err`) is high for exactly the one cycle after the edge that samples that J.
- R4: A bit is 0 when the line state changes from the previous bit time and 1 when it does not. The last K of the start pattern is the reference level. Fields are sent LSB first.
- R5: After six consecutive 1 bits (the final 1 of the start pattern counts), the next bit is dropped. If that dropped bit is 1, the packet ends with `pkt_err` and no other pulse.
- R6: The number of unstuffed bits sets the class: 24 is a token, 32 is a data packet with one payload byte, 8 is a handshake. Any other count gives `pkt_err`.
- R7: The PID is the first 8 bits. It is valid only when bits [7:4] equal the complement of bits [3:0]. An invalid PID gives `pkt_err`.
- R8: A token's 11 bits after the PID (address bits 0-6, then endpoint bits 0-3) are covered by a 5-bit CRC with generator x^5+x^2+1. The CRC register is preset to all ones, and the residual after the CRC field must be 01100. A mismatch gives `pkt_err`.
- R9: A good 24-bit packet with PID low nibble 0001 (OUT) or 1001 (IN) pulses `tok_valid`, with `tok_dir`=1 for IN and 0 for OUT, plus `tok_addr` and `tok_endp`. Any other PID in a 24-bit packet gives `pkt_err`. `tok_dir`, `tok_addr` and `tok_endp` change only with `tok_valid`.
- R10: A 32-bit packet with PID low nibble 0011 or 1011 carries its payload byte in bits 8-15, followed by a CRC with generator x^16+x^15+x^2+1. The CRC register is preset to all ones, and the residual must be 1000000000001101. When the packet is accepted, it pulses `dat_valid` with `dat_byte`; otherwise it pulses `pkt_err`. `dat_byte` changes only with `dat_valid`.
- R11: After reset, and after any token that fails its checks, data packets produce no pulse at all until a good token has been received.
- R12: An 8-bit packet with a valid PID whose low nibble is 0010, 1010 or 1110 produces no pulse.
- R13: At most one of `tok_valid`, `dat_valid` and `pkt_err` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, one line state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_st | input | 2 | Sampled line state: 00 SE0, 01 J, 10 K |
| tok_valid | output | 1 | One-cycle pulse for an accepted token |
| tok_dir | output | 1 | 1 for IN, 0 for OUT |
| tok_addr | output | 7 | Device address of the last accepted token |
| tok_endp | output | 4 | Endpoint of the last accepted token |
| dat_valid | output | 1 | One-cycle pulse for an accepted data byte |
| dat_byte | output | 8 | Payload of the last accepted data packet |
| pkt_err | output | 1 | One-cycle pulse for a rejected packet |

## Verification
Every device address is sent once, with endpoints and directions that vary from address to address, so a swapped or shifted field shows up as a wrong address or endpoint. Every payload byte value is sent behind a good token, alternating the two data PIDs. Dense runs of ones in those bytes force bit stuffing, which separates correct unstuffing from an off-by-one run length. The rejection paths get their own packets:
- a flipped CRC bit;
- a PID whose two nibbles do not complement each other;
- a token PID outside IN/OUT;
- a 16-bit packet;
- a stuffed bit sent as 1;
- handshakes;
- line activity without the start pattern.

Data is also sent before any token and right after a rejected token. Those packets must produce no pulse, which tells the rearm rule apart from plain per-packet checking.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;
    localparam logic [1:0] LN_SE0 = 2'b00;
    localparam logic [1:0] LN_J   = 2'b01;
    localparam logic [1:0] LN_K   = 2'b10;

    localparam int PID_BITS  = 8;
    localparam int ADDR_BITS = 7;
    localparam int ENDP_BITS = 4;
    localparam int CRC5_BITS = 5;
    localparam int CRC16_BITS = 16;
    localparam int BYTE_BITS = 8;
    localparam int HS_BITS   = PID_BITS;
    localparam int TOK_BITS  = PID_BITS + ADDR_BITS + ENDP_BITS + CRC5_BITS;
    localparam int DAT_BITS  = PID_BITS + BYTE_BITS + CRC16_BITS;

    localparam logic [3:0] PN_OUT   = 4'b0001;
    localparam logic [3:0] PN_IN    = 4'b1001;
    localparam logic [3:0] PN_DATA0 = 4'b0011;
    localparam logic [3:0] PN_DATA1 = 4'b1011;
    localparam logic [3:0] PN_ACK   = 4'b0010;
    localparam logic [3:0] PN_NAK   = 4'b1010;
    localparam logic [3:0] PN_STALL = 4'b1110;

    typedef enum logic {ST_HUNT, ST_BODY} rx_state_t;

    function automatic logic pid_good(input logic [7:0] p);
        return p[7:4] == ~p[3:0];
    endfunction
endpackage

// File: rtl/usbrx_unstuff.sv
module usbrx_unstuff
    import usbrx_pkg::*;
#(
    parameter int RUN = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_st,
    input  logic       restart,
    input  logic       active,
    output logic       bit_val,
    output logic       bit_en,
    output logic       stuff_err
);
    localparam int OW = $clog2(RUN + 1);

    logic [1:0]    prev;
    logic [OW-1:0] ones;
    logic          is_bit;
    logic          at_stuff;

    assign is_bit    = active && (line_st == LN_J || line_st == LN_K);
    assign bit_val   = (line_st == prev);
    assign at_stuff  = (ones == OW'(RUN));
    assign bit_en    = is_bit && !at_stuff;
    assign stuff_err = is_bit && at_stuff && bit_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= LN_J;
            ones <= '0;
        end else begin
            prev <= line_st;
            if (restart) begin
                ones <= OW'(1);
            end else if (is_bit) begin
                if (at_stuff || !bit_val) ones <= '0;
                else                      ones <= ones + OW'(1);
            end
        end
    end
endmodule

// File: rtl/usbrx_crc.sv
module usbrx_crc #(
    parameter int           W     = 5,
    parameter logic [W-1:0] POLY  = 5'b00101,
    parameter logic [W-1:0] RESID = 5'b01100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic en,
    input  logic din,
    output logic match
);
    logic [W-1:0] crc;
    logic         fb;

    assign fb    = din ^ crc[W-1];
    assign match = (crc == RESID);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    crc <= '1;
        else if (init) crc <= '1;
        else if (en)   crc <= {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
endmodule

// File: rtl/usbfs_pkt_rx.sv
module usbfs_pkt_rx
    import usbrx_pkg::*;
#(
    parameter int STUFF_RUN = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_st,
    output logic       tok_valid,
    output logic       tok_dir,
    output logic [6:0] tok_addr,
    output logic [3:0] tok_endp,
    output logic       dat_valid,
    output logic [7:0] dat_byte,
    output logic       pkt_err
);
    localparam int SR_W   = DAT_BITS;
    localparam int CNT_W  = $clog2(SR_W + 2);
    localparam int HIST_N = 7;
    localparam logic [2*HIST_N-1:0] SYNC_HEAD =
        {LN_K, LN_J, LN_K, LN_J, LN_K, LN_J, LN_K};
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(SR_W + 1);

    rx_state_t           state, state_nx;
    logic [2*HIST_N-1:0] hist;
    logic                sync_now, eop_now, restart, done;
    logic                bit_val, bit_en, stuff_err, crc_en;
    logic                crc5_ok, crc16_ok;
    logic [SR_W-1:0]     sr;
    logic [CNT_W-1:0]    cnt;
    logic                bad, armed;
    logic [7:0]          tok_pid, dat_pid, hs_pid;
    logic                tok_ok, dat_ok, hs_ok;

    assign sync_now = (hist == SYNC_HEAD) && (line_st == LN_K);
    assign eop_now  = (hist[3:2] == LN_SE0) && (hist[1:0] == LN_SE0) && (line_st == LN_J);
    assign restart  = (state == ST_HUNT) && sync_now;
    assign done     = (state == ST_BODY) && eop_now;
    assign crc_en   = bit_en && (cnt >= CNT_W'(PID_BITS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist <= {HIST_N{LN_J}};
        else        hist <= {hist[2*HIST_N-3:0], line_st};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT: if (sync_now) state_nx = ST_BODY;
            ST_BODY: if (eop_now)  state_nx = ST_HUNT;
        endcase
    end

    usbrx_unstuff #(.RUN(STUFF_RUN)) u_unstuff (
        .clk(clk), .rst_n(rst_n), .line_st(line_st),
        .restart(restart), .active((state == ST_BODY) && !eop_now),
        .bit_val(bit_val), .bit_en(bit_en), .stuff_err(stuff_err)
    );

    usbrx_crc #(.W(CRC5_BITS), .POLY(5'b00101), .RESID(5'b01100)) u_crc5 (
        .clk(clk), .rst_n(rst_n), .init(restart), .en(crc_en),
        .din(bit_val), .match(crc5_ok)
    );

    usbrx_crc #(.W(CRC16_BITS), .POLY(16'h8005), .RESID(16'h800D)) u_crc16 (
        .clk(clk), .rst_n(rst_n), .init(restart), .en(crc_en),
        .din(bit_val), .match(crc16_ok)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr  <= '0;
            cnt <= '0;
            bad <= 1'b0;
        end else if (restart) begin
            cnt <= '0;
            bad <= 1'b0;
        end else if (state == ST_BODY) begin
            if (bit_en) begin
                sr <= {bit_val, sr[SR_W-1:1]};
                if (cnt != CNT_SAT) cnt <= cnt + CNT_W'(1);
            end
            if (stuff_err) bad <= 1'b1;
        end
    end

    assign tok_pid = sr[SR_W-TOK_BITS +: PID_BITS];
    assign dat_pid = sr[SR_W-DAT_BITS +: PID_BITS];
    assign hs_pid  = sr[SR_W-HS_BITS  +: PID_BITS];

    assign tok_ok = pid_good(tok_pid) && crc5_ok &&
                    (tok_pid[3:0] == PN_OUT || tok_pid[3:0] == PN_IN);
    assign dat_ok = pid_good(dat_pid) && crc16_ok &&
                    (dat_pid[3:0] == PN_DATA0 || dat_pid[3:0] == PN_DATA1);
    assign hs_ok  = pid_good(hs_pid) &&
                    (hs_pid[3:0] == PN_ACK || hs_pid[3:0] == PN_NAK || hs_pid[3:0] == PN_STALL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tok_valid <= 1'b0;
            tok_dir   <= 1'b0;
            tok_addr  <= '0;
            tok_endp  <= '0;
            dat_valid <= 1'b0;
            dat_byte  <= '0;
            pkt_err   <= 1'b0;
            armed     <= 1'b0;
        end else begin
            tok_valid <= 1'b0;
            dat_valid <= 1'b0;
            pkt_err   <= 1'b0;
            if (done) begin
                if (cnt == CNT_W'(TOK_BITS)) begin
                    if (tok_ok && !bad) begin
                        tok_valid <= 1'b1;
                        tok_dir   <= (tok_pid[3:0] == PN_IN);
                        tok_addr  <= sr[SR_W-TOK_BITS+PID_BITS +: ADDR_BITS];
                        tok_endp  <= sr[SR_W-TOK_BITS+PID_BITS+ADDR_BITS +: ENDP_BITS];
                        armed     <= 1'b1;
                    end else begin
                        pkt_err <= 1'b1;
                        armed   <= 1'b0;
                    end
                end else if (cnt == CNT_W'(DAT_BITS)) begin
                    if (armed) begin
                        if (dat_ok && !bad) begin
                            dat_valid <= 1'b1;
                            dat_byte  <= sr[SR_W-DAT_BITS+PID_BITS +: BYTE_BITS];
                        end else begin
                            pkt_err <= 1'b1;
                        end
                    end
                end else if (cnt == CNT_W'(HS_BITS)) begin
                    if (!hs_ok || bad) pkt_err <= 1'b1;
                end else begin
                    pkt_err <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/usbfs_pkt_rx_chk.sv
module usbfs_pkt_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] line_st,
    input logic       tok_valid,
    input logic       tok_dir,
    input logic [6:0] tok_addr,
    input logic [3:0] tok_endp,
    input logic       dat_valid,
    input logic [7:0] dat_byte,
    input logic       pkt_err
);
    logic tok_seen;
    logic any_pulse;

    assign any_pulse = tok_valid || dat_valid || pkt_err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         tok_seen <= 1'b0;
        else if (tok_valid) tok_seen <= 1'b1;
    end

    p_one_result_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tok_valid, dat_valid, pkt_err}));

    p_after_eop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        any_pulse |-> ($past(line_st) == 2'b01 && $past(line_st, 2) == 2'b00 &&
                       $past(line_st, 3) == 2'b00));

    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        any_pulse |=> !any_pulse);

    p_tok_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({tok_dir, tok_addr, tok_endp}) |-> tok_valid);

    p_byte_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dat_byte) |-> dat_valid);

    p_data_needs_token_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dat_valid |-> tok_seen);
endmodule

bind usbfs_pkt_rx usbfs_pkt_rx_chk u_chk (.*);

// File: tb/usbfs_pkt_rx_tb.sv
module usbfs_pkt_rx_tb;
    localparam logic [1:0] SE0 = 2'b00;
    localparam logic [1:0] LJ  = 2'b01;
    localparam logic [1:0] LK  = 2'b10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] line_st = LJ;
    logic       tok_valid, tok_dir, dat_valid, pkt_err;
    logic [6:0] tok_addr;
    logic [3:0] tok_endp;
    logic [7:0] dat_byte;

    int n_tok, n_dat, n_err;
    logic       s_dir;
    logic [6:0] s_addr;
    logic [3:0] s_endp;
    logic [7:0] s_byte;
    int vecs = 0;
    int fails = 0;

    always #2 clk = ~clk;

    usbfs_pkt_rx u_dut (
        .clk(clk), .rst_n(rst_n), .line_st(line_st),
        .tok_valid(tok_valid), .tok_dir(tok_dir), .tok_addr(tok_addr),
        .tok_endp(tok_endp), .dat_valid(dat_valid), .dat_byte(dat_byte),
        .pkt_err(pkt_err)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (tok_valid) begin
                n_tok++; s_dir = tok_dir; s_addr = tok_addr; s_endp = tok_endp;
            end
            if (dat_valid) begin n_dat++; s_byte = dat_byte; end
            if (pkt_err) n_err++;
        end
    end

    task automatic chk(input int act, input int exp, input string req, input string what);
        vecs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [1:0] s);
        @(negedge clk);
        line_st = s;
    endtask

    function automatic logic [31:0] mk_tok(input logic [3:0] pn, input logic [6:0] a, input logic [3:0] e);
        logic [4:0]  c = 5'h1f;
        logic [10:0] f = {e, a};
        logic [31:0] v = '0;
        for (int i = 0; i < 11; i++) begin
            logic fb = f[i] ^ c[4];
            c = {c[3:0], 1'b0} ^ (fb ? 5'b00101 : 5'b00000);
        end
        v[7:0]  = {~pn, pn};
        v[18:8] = f;
        for (int i = 0; i < 5; i++) v[19+i] = ~c[4-i];
        return v;
    endfunction

    function automatic logic [31:0] mk_dat(input logic [3:0] pn, input logic [7:0] b);
        logic [15:0] c = 16'hffff;
        logic [31:0] v = '0;
        for (int i = 0; i < 8; i++) begin
            logic fb = b[i] ^ c[15];
            c = {c[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
        end
        v[7:0]  = {~pn, pn};
        v[15:8] = b;
        for (int i = 0; i < 16; i++) v[16+i] = ~c[15-i];
        return v;
    endfunction

    task automatic send(input logic [31:0] v, input int n, input bit brk);
        logic [1:0] lvl = LK;
        int ones = 1;
        n_tok = 0; n_dat = 0; n_err = 0;
        put(LJ); put(LJ);
        put(LK); put(LJ); put(LK); put(LJ); put(LK); put(LJ); put(LK); put(LK);
        for (int i = 0; i < n; i++) begin
            if (!v[i]) lvl = (lvl == LK) ? LJ : LK;
            put(lvl);
            ones = v[i] ? ones + 1 : 0;
            if (ones == 6) begin
                if (!brk) lvl = (lvl == LK) ? LJ : LK;
                put(lvl);
                ones = 0;
            end
        end
        put(SE0); put(SE0); put(LJ); put(LJ); put(LJ);
    endtask

    task automatic expect_counts(input int t, input int d, input int e, input string req);
        chk(n_tok, t, req, "token pulses");
        chk(n_dat, d, req, "data pulses");
        chk(n_err, e, req, "error pulses");
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: got 0 expected 1 completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({30'd0, tok_valid, dat_valid} | {31'd0, pkt_err}, 0, "R1", "pulses in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk({tok_valid, dat_valid, pkt_err}, 0, "R1", "pulses after release");

        send(mk_dat(4'b0011, 8'h5A), 32, 1'b0);
        expect_counts(0, 0, 0, "R11 data before token");

        n_tok = 0; n_dat = 0; n_err = 0;
        put(LK); put(LJ); put(LK); put(LK); put(LJ); put(LK); put(SE0); put(SE0); put(LJ); put(LJ); put(LJ);
        expect_counts(0, 0, 0, "R2 no start pattern");

        for (int a = 0; a < 128; a++) begin
            logic [3:0] e = 4'((a * 5 + 3) % 16);
            logic       d = a[0];
            send(mk_tok(d ? 4'b1001 : 4'b0001, 7'(a), e), 24, 1'b0);
            chk(n_tok, 1, "R9 R8 R3 R2", "token pulse");
            chk(n_err, 0, "R8", "token error");
            chk({28'd0, s_dir}, {28'd0, d}, "R9", "direction");
            chk({25'd0, s_addr}, a, "R4 R9", "address");
            chk({28'd0, s_endp}, {28'd0, e}, "R4 R9", "endpoint");
        end

        for (int b = 0; b < 256; b++) begin
            send(mk_dat(b[0] ? 4'b1011 : 4'b0011, 8'(b)), 32, 1'b0);
            chk(n_dat, 1, "R10 R5", "data pulse");
            chk({24'd0, s_byte}, b, "R4 R10", "data byte");
        end

        send(mk_dat(4'b0011, 8'h3C) ^ 32'h0001_0000, 32, 1'b0);
        expect_counts(0, 0, 1, "R10 bad data crc");

        send(mk_dat(4'b0011, 8'hFF), 32, 1'b1);
        expect_counts(0, 0, 1, "R5 stuff error");

        send(mk_tok(4'b0001, 7'h11, 4'h2) ^ 32'h0020_0000, 24, 1'b0);
        expect_counts(0, 0, 1, "R8 bad token crc");
        send(mk_dat(4'b1011, 8'h77), 32, 1'b0);
        expect_counts(0, 0, 0, "R11 data after bad token");

        send(mk_tok(4'b0001, 7'h11, 4'h2) ^ 32'h0000_0010, 24, 1'b0);
        expect_counts(0, 0, 1, "R7 token pid complement");

        send(mk_tok(4'b1101, 7'h22, 4'h5), 24, 1'b0);
        expect_counts(0, 0, 1, "R9 non IN/OUT token pid");

        send(mk_tok(4'b0001, 7'h33, 4'h6), 24, 1'b0);
        expect_counts(1, 0, 0, "R9 rearm token");
        send(mk_dat(4'b0011, 8'hA5), 32, 1'b0);
        expect_counts(0, 1, 0, "R11 data after rearm");
        chk({24'd0, s_byte}, 32'hA5, "R10", "byte after rearm");

        send({24'd0, 8'b1101_0010}, 8, 1'b0);
        expect_counts(0, 0, 0, "R12 ack");
        send({24'd0, 8'b0101_1010}, 8, 1'b0);
        expect_counts(0, 0, 0, "R12 nak");
        send({24'd0, 8'b0001_1110}, 8, 1'b0);
        expect_counts(0, 0, 0, "R12 stall");
        send({24'd0, 8'b1111_0010}, 8, 1'b0);
        expect_counts(0, 0, 1, "R7 handshake pid");

        send({16'd0, mk_dat(4'b0011, 8'h42)}, 16, 1'b0);
        expect_counts(0, 0, 1, "R6 sixteen bits");
        send(mk_dat(4'b0011, 8'h42), 20, 1'b0);
        expect_counts(0, 0, 1, "R6 twenty bits");

        chk({29'd0, tok_valid, dat_valid, pkt_err}, 0, "R13", "idle after tests");

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule